// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs the transfer sequence of a single DMA channel. It holds a read address, a write address, a transfer count and a 16-bit control word. Once started, it moves one element at a time. It reads an element from the read address, optionally reverses its bytes, and writes it to the write address. The addresses then advance according to the element size, the two increment enables and an optional power-of-two ring wrap. When the count reaches zero the channel can raise a one-cycle interrupt and can launch another channel.

Software programs the channel through a write-only port: `reg_valid`, a 3-bit address and 32 bits of data. Bits [1:0] of the address select the register, as 0 for control, 1 for the read address, 2 for the write address and 3 for the count. Bit 2 set makes the write a trigger write. A trigger write stores the value and also starts the channel. The bus side uses two request/acknowledge pairs, one for reads and one for writes. Only one element is ever in flight.

Control word fields: bit 0 enable, bits [2:1] size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), bit 3 read increment, bit 4 write increment, bits [8:5] ring width n, bit 9 ring on the write side, bits [13:10] chain target, bit 14 byte reverse, bit 15 quiet.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is idle and issues no requests. The control word holds 0x0000_080D for channel 2: enabled, 32-bit size, read increment on, write increment off, no ring, chain to itself, no swap, not quiet.
- R2: The size field sets the step of each address: 1, 2 or 4 bytes for codes 0, 1 and 2. `rd_size` and `wr_size` carry the code.
- R3: Each side has its own increment enable. With it off, every access on that side uses the start address.
- R4: A run performs exactly as many element transfers as the count value. The count falls by one as each write is acknowledged.
- R5: With ring width n in 1..15, only the low n address bits of the selected side change, so that side cycles inside a 2^n-byte aligned window. Bit 9 picks the write side when 1 and the read side when 0. n = 0 disables wrapping.
- R6: With byte reverse on, 8-bit data passes unchanged. For 16-bit data the two bytes of each halfword trade places. For 32-bit data all four bytes are reversed.
- R7: When the count runs out, `busy` falls and, unless quiet is set, `irq` pulses for one cycle. If the chain target differs from the channel's own number, `chain_valid` pulses with `chain_idx` equal to the target.
- R8: In quiet mode a finished run raises no interrupt. A trigger write of zero data raises `irq` and does not start the channel. The quiet bit is taken from the control word as it stood before that write.
- R9: While enable is low, trigger writes and `chain_in` do not start the channel. A busy channel issues no new read but stays busy, and it resumes when enable is set again.
- R10: A write with address bit 2 clear only stores the value. The same write with bit 2 set also starts the channel, for any of the four registers.
- R11: `abort_req` on a busy channel prevents further element reads. The element in flight completes its write, then `busy` clears with no interrupt and no chain pulse, even when the abort coincides with the final write.
- R12: Reads and writes never overlap. A write is requested only after the matching read data has been acknowledged.
- R13: A pulse on `chain_in` starts an idle, enabled channel with its stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register write strobe |
| reg_addr | input | 3 | [1:0] register select, [2] trigger |
| reg_wdata | input | 32 | Register write data |
| chain_in | input | 1 | Start pulse from another channel |
| abort_req | input | 1 | Abort pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_size | output | 2 | Read element size code |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_size | output | 2 | Write element size code |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Channel running or paused |
| irq | output | 1 | One-cycle interrupt pulse |
| chain_valid | output | 1 | One-cycle chain launch pulse |
| chain_idx | output | 4 | Channel to launch |

## Verification
Abort and completion can land in the same cycle. This happens when `abort_req` is sampled on the same edge as the acknowledge of the run's last write. The bench provokes it by watching for the final write request and raising the abort on the edge where its bus model acknowledges that write. It then expects every write to have arrived, `busy` to have cleared, and no interrupt or chain pulse. A second pairing, a trigger write and a pause arriving around an element in flight, is judged by the count of writes staying frozen while `busy` remains high.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int CHAIN_W = 4;
  localparam int RING_W  = 4;

  typedef struct packed {
    logic               quiet;
    logic               bswap;
    logic [CHAIN_W-1:0] chain_to;
    logic               ring_wr;
    logic [RING_W-1:0]  ring_n;
    logic               inc_wr;
    logic               inc_rd;
    logic [1:0]         size;
    logic               en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RD   = 2'd1,
    SEL_WR   = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;

  // bytes per element for a size code
  function automatic logic [ADDR_W-1:0] elem_step(input logic [1:0] size);
    case (size)
      2'd0:    elem_step = ADDR_W'(1);
      2'd1:    elem_step = ADDR_W'(2);
      default: elem_step = ADDR_W'(4);
    endcase
  endfunction

  // next address: optional increment, optional ring window of 2^n bytes
  function automatic logic [ADDR_W-1:0] next_addr(
    input logic [ADDR_W-1:0] cur,
    input logic [1:0]        size,
    input logic              inc,
    input logic [RING_W-1:0] ring_n,
    input logic              wrap_here
  );
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] keep;
    sum  = cur + elem_step(size);
    keep = '0;
    if (wrap_here && ring_n != '0)
      keep = ~((ADDR_W'(1) << ring_n) - ADDR_W'(1));
    if (!inc)
      next_addr = cur;
    else
      next_addr = (cur & keep) | (sum & ~keep);
  endfunction

  // byte order reversal inside each element
  function automatic logic [DATA_W-1:0] lane_swap(
    input logic [DATA_W-1:0] d,
    input logic [1:0]        size,
    input logic              on
  );
    if (!on || size == 2'd0)
      lane_swap = d;
    else if (size == 2'd1)
      lane_swap = {d[23:16], d[31:24], d[7:0], d[15:8]};
    else
      lane_swap = {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

endpackage

// File: rtl/dma_seq_step.sv
module dma_seq_step
  import dma_seq_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0
) (
  input  logic [ADDR_W-1:0] cur,
  input  ctrl_t             ctrl,
  output logic [ADDR_W-1:0] nxt
);

  logic side_inc;
  logic side_wrap;

  assign side_inc  = IS_WRITE ? ctrl.inc_wr : ctrl.inc_rd;
  assign side_wrap = (ctrl.ring_wr == IS_WRITE);
  assign nxt       = next_addr(cur, ctrl.size, side_inc, ctrl.ring_n, side_wrap);

endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int CH_ID = 2,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] rd_next,
  input  logic [ADDR_W-1:0] wr_next,
  output logic [ADDR_W-1:0] rd_addr_q,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [CNT_W-1:0]  count_q,
  output ctrl_t             ctrl_q
);

  localparam ctrl_t CTRL_RST = '{
    quiet:    1'b0,
    bswap:    1'b0,
    chain_to: CHAIN_W'(CH_ID),
    ring_wr:  1'b0,
    ring_n:   '0,
    inc_wr:   1'b0,
    inc_rd:   1'b1,
    size:     2'd2,
    en:       1'b1
  };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      count_q   <= '0;
      ctrl_q    <= CTRL_RST;
    end else begin
      if (step_en) begin
        rd_addr_q <= rd_next;
        wr_addr_q <= wr_next;
        count_q   <= count_q - CNT_W'(1);
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: ctrl_q    <= ctrl_t'(wr_val[CTRL_W-1:0]);
          SEL_RD:   rd_addr_q <= wr_val[ADDR_W-1:0];
          SEL_WR:   wr_addr_q <= wr_val[ADDR_W-1:0];
          default:  count_q   <= wr_val[CNT_W-1:0];
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_seq_engine.sv
module dma_seq_engine
  import dma_seq_pkg::*;
#(
  parameter int CH_ID = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               null_irq,
  input  logic               abort_req,
  input  logic               en,
  input  logic               quiet,
  input  logic [CHAIN_W-1:0] chain_to,
  input  logic               count_zero,
  input  logic               rd_ack,
  input  logic               wr_ack,
  output logic               busy,
  output logic               rd_req,
  output logic               wr_req,
  output logic               step_en,
  output logic               rd_fire,
  output logic               abort_pend,
  output logic               irq,
  output logic               chain_valid,
  output logic [CHAIN_W-1:0] chain_idx
);

  st_e  state_q;
  logic at_idle;
  logic fin_abort;
  logic fin_done;

  assign at_idle   = (state_q == ST_IDLE);
  assign rd_req    = (state_q == ST_READ);
  assign wr_req    = (state_q == ST_WRITE);
  assign rd_fire   = rd_req & rd_ack;
  assign step_en   = wr_req & wr_ack;
  assign fin_abort = at_idle & busy & abort_pend;
  assign fin_done  = at_idle & busy & !abort_pend & count_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      busy        <= 1'b0;
      abort_pend  <= 1'b0;
      irq         <= 1'b0;
      chain_valid <= 1'b0;
      chain_idx   <= '0;
    end else begin
      irq         <= null_irq | (fin_done & !quiet);
      chain_valid <= fin_done & (chain_to != CHAIN_W'(CH_ID));
      if (fin_done)
        chain_idx <= chain_to;
      if (abort_req && busy)
        abort_pend <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (fin_abort || fin_done) begin
            busy       <= 1'b0;
            abort_pend <= 1'b0;
          end else if (busy) begin
            if (en && !abort_req)
              state_q <= ST_READ;
          end else if (start) begin
            busy <= 1'b1;
          end
        end
        ST_READ:  if (rd_ack) state_q <= ST_WRITE;
        ST_WRITE: if (wr_ack) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int CH_ID = 2,
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_valid,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               chain_in,
  input  logic               abort_req,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [1:0]         rd_size,
  input  logic               rd_ack,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               wr_req,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [1:0]         wr_size,
  output logic [DATA_W-1:0]  wr_data,
  input  logic               wr_ack,
  output logic               busy,
  output logic               irq,
  output logic               chain_valid,
  output logic [CHAIN_W-1:0] chain_idx
);

  localparam int SIDES = 2;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] rd_q;
  logic [ADDR_W-1:0] wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] cur_a [SIDES];
  logic [ADDR_W-1:0] nxt_a [SIDES];
  logic [DATA_W-1:0] data_q;

  // named internal events for the checker
  logic     step_en;
  logic     rd_fire;
  logic     abort_pend;
  logic     trig_wr;
  logic     en_after;
  logic     null_trig;
  logic     start_evt;
  reg_sel_e sel;

  assign sel       = reg_sel_e'(reg_addr[1:0]);
  assign trig_wr   = reg_valid & reg_addr[2];
  assign en_after  = (sel == SEL_CTRL) ? reg_wdata[0] : ctrl.en;
  assign null_trig = trig_wr & ctrl.quiet & (reg_wdata == '0);
  assign start_evt = (trig_wr & en_after & !null_trig) | (chain_in & ctrl.en);

  assign cur_a[0] = rd_q;
  assign cur_a[1] = wr_q;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_seq_step #(.IS_WRITE(g == 1)) u_step (
      .cur  (cur_a[g]),
      .ctrl (ctrl),
      .nxt  (nxt_a[g])
    );
  end

  dma_seq_regs #(.CH_ID(CH_ID), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_valid),
    .wr_sel    (sel),
    .wr_val    (reg_wdata),
    .step_en   (step_en),
    .rd_next   (nxt_a[0]),
    .wr_next   (nxt_a[1]),
    .rd_addr_q (rd_q),
    .wr_addr_q (wr_q),
    .count_q   (cnt_q),
    .ctrl_q    (ctrl)
  );

  dma_seq_engine #(.CH_ID(CH_ID)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_evt),
    .null_irq    (null_trig),
    .abort_req   (abort_req),
    .en          (ctrl.en),
    .quiet       (ctrl.quiet),
    .chain_to    (ctrl.chain_to),
    .count_zero  (cnt_q == '0),
    .rd_ack      (rd_ack),
    .wr_ack      (wr_ack),
    .busy        (busy),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .step_en     (step_en),
    .rd_fire     (rd_fire),
    .abort_pend  (abort_pend),
    .irq         (irq),
    .chain_valid (chain_valid),
    .chain_idx   (chain_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (rd_fire)
      data_q <= lane_swap(rd_data, ctrl.size, ctrl.bswap);
  end

  assign rd_addr = rd_q;
  assign wr_addr = wr_q;
  assign rd_size = ctrl.size;
  assign wr_size = ctrl.size;
  assign wr_data = data_q;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int CH_ID = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_req,
  input logic               rd_ack,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               wr_req,
  input logic               busy,
  input logic               chain_valid,
  input logic [CHAIN_W-1:0] chain_idx,
  input logic               abort_pend
);

  // R12
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // R12
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_ack));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R9
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req));

  // R7
  chain_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_valid |-> (chain_idx != CHAIN_W'(CH_ID)));

  // R11
  abort_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_pend && !rd_req && !wr_req) |=> !busy);

endmodule

bind dma_chan_seq dma_seq_chk #(.CH_ID(CH_ID)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .rd_ack      (rd_ack),
  .rd_addr     (rd_addr),
  .wr_req      (wr_req),
  .busy        (busy),
  .chain_valid (chain_valid),
  .chain_idx   (chain_idx),
  .abort_pend  (abort_pend)
);

// File: tb/dma_chan_seq_tb_top.sv
`timescale 1ns/1ps
module dma_chan_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        chain_in = 1'b0;
  logic        abort_req = 1'b0;
  logic        rd_req, wr_req, busy, irq, chain_valid;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [1:0]  rd_size, wr_size;
  logic        rd_ack = 1'b0;
  logic        wr_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic [3:0]  chain_idx;

  always #10 clk = ~clk;

  dma_chan_seq #(.CH_ID(2), .CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .chain_in(chain_in), .abort_req(abort_req),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_ack(rd_ack),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy), .irq(irq),
    .chain_valid(chain_valid), .chain_idx(chain_idx)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    wr_seen = 0;
  int    irq_cnt = 0;
  int    chain_cnt = 0;
  logic [3:0]  chain_last = '0;
  logic [31:0] last_rd = '0;
  string cur_req = "R1";
  logic [97:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [97:0] act, input logic [97:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench-side model of memory, stepping and byte order
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[7:0] + 8'd3, a[7:0] + 8'd2, a[7:0] + 8'd1, a[7:0]};
  endfunction

  function automatic logic [31:0] m_adv(input logic [31:0] a, input int sz,
                                        input bit inc, input int n, input bit wrap);
    longint unsigned span, base, stp;
    stp = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (!inc) return a;
    if (wrap && n != 0) begin
      span = longint'(1) << n;
      base = a - (a % span);
      return 32'(base + ((a - base + stp) % span));
    end
    return a + 32'(stp);
  endfunction

  function automatic logic [31:0] m_swap(input logic [31:0] d, input int sz, input bit on);
    logic [31:0] r;
    r = d;
    if (on && sz == 1) begin
      for (int h = 0; h < 2; h++) begin
        r[h*16 +: 8]     = d[h*16 + 8 +: 8];
        r[h*16 + 8 +: 8] = d[h*16 +: 8];
      end
    end else if (on && sz == 2) begin
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = d[(3-b)*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit en, input int sz, input bit ir,
      input bit iw, input int rn, input bit rw, input int ch, input bit bs, input bit q);
    return 32'(en) | 32'(sz << 1) | 32'(ir) << 3 | 32'(iw) << 4 | 32'(rn << 5)
         | 32'(rw) << 9 | 32'(ch << 10) | 32'(bs) << 14 | 32'(q) << 15;
  endfunction

  // bus model and scoreboard monitor
  always @(negedge clk) begin
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      rd_ack  = 1'b1;
      rd_data = mem_word(rd_addr);
      last_rd = rd_addr;
    end
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      logic [97:0] got;
      wr_ack = 1'b1;
      wr_seen++;
      got = {wr_size, last_rd, wr_addr, wr_data};
      if (exp_q.size() == 0) check(1'b0, cur_req, "unexpected write", got, '0);
      else begin
        logic [97:0] e;
        e = exp_q.pop_front();
        check(got == e, cur_req, "write item", got, e);
      end
    end
    if (irq) irq_cnt++;
    if (chain_valid) begin
      chain_cnt++;
      chain_last = chain_idx;
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic push_run(input logic [31:0] r0, input logic [31:0] w0, input int n,
                          input logic [31:0] c);
    logic [31:0] ra, wa;
    int sz, rn;
    sz = int'(c[2:1]); rn = int'(c[8:5]);
    ra = r0; wa = w0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({c[2:1], ra, wa, m_swap(mem_word(ra), sz, c[14])});
      ra = m_adv(ra, sz, c[3], rn, !c[9]);
      wa = m_adv(wa, sz, c[4], rn, c[9]);
    end
  endtask

  task automatic setup_run(input logic [31:0] r0, input logic [31:0] w0, input int n,
                           input logic [31:0] c);
    reg_wr(3'd0, c);
    reg_wr(3'd1, r0);
    reg_wr(3'd2, w0);
    push_run(r0, w0, n, c);
    reg_wr(3'd7, 32'(n));
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    while (busy && k < 3000) begin @(negedge clk); k++; end
    check(!busy, req, "busy timeout", 98'(busy), 98'(0));
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int base, ic, cc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !rd_req && !wr_req && !irq, "R1", "reset outputs",
          98'({busy, rd_req, wr_req, irq}), 98'(0));

    // R10 plain writes store only
    cur_req = "R10";
    reg_wr(3'd1, 32'h100); reg_wr(3'd2, 32'h2000); reg_wr(3'd3, 32'd3);
    repeat (5) @(negedge clk);
    check(!busy && wr_seen == 0, "R10", "plain write started", 98'(wr_seen), 98'(0));

    // R1 R4 default control word, started through count trigger alias
    cur_req = "R1";
    push_run(32'h100, 32'h2000, 3, 32'h80D);
    reg_wr(3'd7, 32'd3);
    wait_idle("R4");
    check(wr_seen == 3, "R4", "transfer count", 98'(wr_seen), 98'(3));
    check(irq_cnt == 1, "R7", "irq after run", 98'(irq_cnt), 98'(1));
    check(chain_cnt == 0, "R7", "self chain silent", 98'(chain_cnt), 98'(0));

    // R2 R6 byte data ignores swap, both sides step by 1
    cur_req = "R6";
    setup_run(32'h301, 32'h401, 4, mk_ctrl(1, 0, 1, 1, 0, 0, 2, 1, 0));
    wait_idle("R2");
    // R6 halfword swap, step 2
    setup_run(32'h500, 32'h600, 3, mk_ctrl(1, 1, 1, 1, 0, 0, 2, 1, 0));
    wait_idle("R6");
    // R3 word reverse, read side fixed
    cur_req = "R3";
    setup_run(32'h700, 32'h800, 2, mk_ctrl(1, 2, 0, 1, 0, 0, 2, 1, 0));
    wait_idle("R3");
    // R5 ring on read side, n=4
    cur_req = "R5";
    setup_run(32'h10C, 32'h900, 4, mk_ctrl(1, 2, 1, 1, 4, 0, 2, 0, 0));
    wait_idle("R5");
    // R5 ring on write side, n=3, halfwords
    setup_run(32'hB00, 32'hA06, 5, mk_ctrl(1, 1, 1, 1, 3, 1, 2, 0, 0));
    wait_idle("R5");
    check(exp_q.size() == 0, "R5", "items left", 98'(exp_q.size()), 98'(0));

    // R7 R8 chain to 5 with quiet: chain pulse, no irq
    cur_req = "R7";
    ic = irq_cnt; cc = chain_cnt;
    setup_run(32'h40, 32'h80, 2, mk_ctrl(1, 2, 1, 1, 0, 0, 5, 0, 1));
    wait_idle("R7");
    check(chain_cnt == cc + 1 && chain_last == 4'd5, "R7", "chain pulse",
          98'({chain_cnt, chain_last}), 98'({cc + 1, 4'd5}));
    check(irq_cnt == ic, "R8", "quiet run irq", 98'(irq_cnt), 98'(ic));

    // R8 null trigger in quiet: irq, no start
    base = wr_seen;
    reg_wr(3'd3, 32'd2);
    reg_wr(3'd5, 32'h0);
    repeat (4) @(negedge clk);
    check(irq_cnt == ic + 1 && !busy && wr_seen == base, "R8", "null trigger",
          98'({irq_cnt, busy}), 98'({ic + 1, 1'b0}));

    // R9 trigger with enable low does not start
    reg_wr(3'd4, mk_ctrl(0, 2, 1, 1, 0, 0, 2, 0, 0));
    repeat (5) @(negedge clk);
    check(!busy && wr_seen == base, "R9", "disabled trigger", 98'(busy), 98'(0));

    // R9 pause mid run, then resume
    cur_req = "R9";
    setup_run(32'h1000, 32'h1400, 6, mk_ctrl(1, 2, 1, 1, 0, 0, 2, 0, 0));
    while (wr_seen < base + 2) @(negedge clk);
    reg_wr(3'd0, mk_ctrl(0, 2, 1, 1, 0, 0, 2, 0, 0));
    repeat (4) @(negedge clk);
    ic = wr_seen;
    repeat (20) @(negedge clk);
    check(busy && wr_seen == ic && !rd_req, "R9", "paused",
          98'({busy, wr_seen}), 98'({1'b1, ic}));
    reg_wr(3'd0, mk_ctrl(1, 2, 1, 1, 0, 0, 2, 0, 0));
    wait_idle("R9");
    check(wr_seen == base + 6, "R9", "resumed total", 98'(wr_seen), 98'(base + 6));

    // R11 abort while second write is in flight
    cur_req = "R11";
    base = wr_seen; ic = irq_cnt;
    setup_run(32'h2000, 32'h2400, 8, mk_ctrl(1, 2, 1, 1, 0, 0, 2, 0, 0));
    do begin @(posedge clk); #1; end while (!(wr_req && wr_seen == base + 1));
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    wait_idle("R11");
    check(wr_seen == base + 2 && irq_cnt == ic, "R11", "abort drain",
          98'({wr_seen, irq_cnt}), 98'({base + 2, ic}));
    exp_q.delete();

    // R11 abort coinciding with final write acknowledge
    base = wr_seen; cc = chain_cnt;
    setup_run(32'h3000, 32'h3400, 3, mk_ctrl(1, 2, 1, 1, 0, 0, 6, 0, 0));
    do begin @(posedge clk); #1; end while (!(wr_req && wr_seen == base + 2));
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    wait_idle("R11");
    check(wr_seen == base + 3 && irq_cnt == ic && chain_cnt == cc, "R11",
          "abort at final", 98'({wr_seen, irq_cnt, chain_cnt}), 98'({base + 3, ic, cc}));

    // R13 chain_in starts a stored setup
    cur_req = "R13";
    base = wr_seen;
    reg_wr(3'd0, mk_ctrl(1, 2, 1, 0, 0, 0, 2, 0, 0));
    reg_wr(3'd1, 32'h50); reg_wr(3'd2, 32'h60); reg_wr(3'd3, 32'd2);
    push_run(32'h50, 32'h60, 2, mk_ctrl(1, 2, 1, 0, 0, 0, 2, 0, 0));
    @(negedge clk); chain_in = 1'b1;
    @(negedge clk); chain_in = 1'b0;
    wait_idle("R13");
    check(wr_seen == base + 2 && exp_q.size() == 0, "R13", "chain start",
          98'(wr_seen), 98'(base + 2));

    finish_up();
  end

endmodule